// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is the synchronous front end of a small on-chip static memory. Address, control and write data are registered on the rising clock edge. The array is accessed on the following edge. Read data then leaves through an output register, so the data flag is raised two edges after the request was presented. Each word holds four lanes of nine bits: eight data bits plus one parity bit, which is stored and returned with its byte.

A burst can be opened by either of two start strobes. The processor-style start is masked by the primary enable and always opens a read. The controller-style start opens a read or a write, as the write controls in the same cycle select. Later cycles either advance the two low address bits, in linear or interleaved order, or repeat the current word.

Three enables and a sleep input can deselect the block. Deselect is single-cycle: a read already in flight still reaches the output, and the output flag then drops. The output enable only gates the output and has no effect on the internal cycle.

Top module: `sram_burst_ctrl`

## Requirements
- R1: A controller start (`start_ctrl_n` low while no qualified processor start is present) with all enables active opens a burst at `addr`. It is a write when the write controls of that cycle request any lane, and a read otherwise.
- R2: A processor start (`start_proc_n` low with `en_n` low) and active secondary enables always opens a read burst, whatever the write controls. With `en_n` high, `start_proc_n` is ignored and the cycle is a continue or suspend cycle.
- R3: In the cycle right after a processor start, a write request with `adv_n` high writes the word at the loaded address. With `adv_n` low the write is discarded: nothing is written, the burst address does not move, and no read data is produced.
- R4: Lane i occupies bits [9i+8:9i], and bit 9i+8 is that lane's parity. If `gwr_n` is low, all lanes are written. If `gwr_n` is high and `bwr_n` is low, only the lanes whose `lane_wr_n` bit is low are written. If no lane is selected, the cycle is a read.
- R5: A non-start cycle on a selected device accesses the next burst address when `adv_n` is low, and the current address again when `adv_n` is high. The two low address bits step as start+n modulo 4 when `burst_ilv` is 0, and as start XOR n when it is 1. The upper bits stay fixed.
- R6: Data for a read presented before rising edge N appears after edge N+1. A read of an address written in the cycle just before it returns the newly written lanes.
- R7: A controller start with `en_n` high, or any start with `en_aux` low or `en_aux_n` high, deselects the block. A read issued in the cycle before the deselect still reaches the output, and the flag is low after the edge that follows the deselect.
- R8: While deselected, continue and suspend cycles, writes included, leave the array untouched and the block deselected.
- R9: `oe_n` high forces `rdata_oe` low and `rdata` to zero at once, without disturbing the internal cycle.
- R10: The edge after `sleep` is first sampled high deselects the block, and inputs are ignored from then on. Inputs stay ignored until the second edge after `sleep` is sampled low. `rdata_oe` is low meanwhile.
- R11: During and after reset, before any read, `rdata_oe` is low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Snooze request |
| en_n | input | 1 | Primary enable, active low; masks processor start |
| en_aux | input | 1 | Secondary enable, active high, sampled with starts |
| en_aux_n | input | 1 | Secondary enable, active low, sampled with starts |
| start_proc_n | input | 1 | Processor-style burst start, active low |
| start_ctrl_n | input | 1 | Controller-style burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Write all lanes, active low |
| bwr_n | input | 1 | Lane-write enable, active low |
| lane_wr_n | input | 4 | Per-lane write select, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data is driven |

## Verification
The hardest situation to reach from the ports is a cycle that must leave no trace. Examples are a write discarded after a processor start, a write attempted while deselected, and writes offered during snooze and its two-cycle recovery. In each case the ignored write targets an address that already holds known data. A later burst reads that address back, and any leak shows up as a mismatch in a specific lane. Both burst orders are driven through a wrap and a suspend, so the beats themselves show the counter sequence.

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] ofs_in,
  input  logic             step,
  input  logic             ilv,
  output logic [OFS_W-1:0] ofs_cur,
  output logic [OFS_W-1:0] ofs_nxt
);
  logic [OFS_W-1:0] base, cnt;
  logic [OFS_W-1:0] cnt_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      cnt  <= '0;
    end else if (load) begin
      base <= ofs_in;
      cnt  <= '0;
    end else if (step) begin
      cnt  <= cnt_n;
    end
  end

  assign cnt_n   = cnt + OFS_W'(1);
  assign ofs_cur = ilv ? (base ^ cnt)   : (base + cnt);
  assign ofs_nxt = ilv ? (base ^ cnt_n) : (base + cnt_n);
endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    en_n,
  input  logic                    en_aux,
  input  logic                    en_aux_n,
  input  logic                    start_proc_n,
  input  logic                    start_ctrl_n,
  input  logic                    adv_n,
  input  logic                    gwr_n,
  input  logic                    bwr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    burst_ilv,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int OFS_W  = 2;

  logic snz_d1, snz_d2, snooze;
  logic sel, after_ps;
  logic [ADDR_W-1:OFS_W] addr_hi;
  logic [LANES-1:0] wr_lanes;
  logic wr_req, ps_go, cs_go, start, begin_ok, desel, cont, drop, acc_go, acc_we_nx;
  logic [ADDR_W-1:0] acc_addr_nx;
  logic [OFS_W-1:0] ofs_cur, ofs_nxt;

  logic              acc_valid, acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_be;
  logic [WORD_W-1:0] acc_data;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] q;
  logic              q_valid;

  assign snooze   = snz_d1 | snz_d2;
  assign wr_lanes = !gwr_n ? '1 : (!bwr_n ? ~lane_wr_n : '0);
  assign wr_req   = |wr_lanes;
  assign ps_go    = !start_proc_n && !en_n;
  assign cs_go    = !ps_go && !start_ctrl_n;
  assign start    = ps_go || cs_go;
  assign begin_ok = start && !en_n && en_aux && !en_aux_n;
  assign desel    = start && !begin_ok;
  assign cont     = !start && sel;
  assign drop     = cont && after_ps && wr_req && !adv_n;
  assign acc_go   = begin_ok || (cont && !drop);
  assign acc_we_nx   = wr_req && !ps_go;
  assign acc_addr_nx = begin_ok ? addr : {addr_hi, (adv_n ? ofs_cur : ofs_nxt)};

  sram_burst_seq #(.OFS_W(OFS_W)) seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (begin_ok && !snooze),
    .ofs_in (addr[OFS_W-1:0]),
    .step   (cont && !adv_n && !drop && !snooze),
    .ilv    (burst_ilv),
    .ofs_cur(ofs_cur),
    .ofs_nxt(ofs_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snz_d1    <= 1'b0;
      snz_d2    <= 1'b0;
      sel       <= 1'b0;
      after_ps  <= 1'b0;
      acc_valid <= 1'b0;
      acc_we    <= 1'b0;
      acc_addr  <= '0;
      acc_be    <= '0;
      acc_data  <= '0;
      addr_hi   <= '0;
    end else begin
      snz_d1 <= sleep;
      snz_d2 <= snz_d1;
      if (snooze) begin
        sel       <= 1'b0;
        after_ps  <= 1'b0;
        acc_valid <= 1'b0;
      end else begin
        if (begin_ok)   sel <= 1'b1;
        else if (desel) sel <= 1'b0;
        after_ps  <= begin_ok && ps_go;
        acc_valid <= acc_go;
        acc_we    <= acc_we_nx;
        acc_addr  <= acc_addr_nx;
        acc_be    <= wr_lanes;
        acc_data  <= wdata;
        if (begin_ok) addr_hi <= addr[ADDR_W-1:OFS_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc_valid && acc_we) begin
      for (int i = 0; i < LANES; i++) begin
        if (acc_be[i]) mem[acc_addr][i*LANE_W +: LANE_W] <= acc_data[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= acc_valid && !acc_we;
      if (acc_valid && !acc_we) q <= mem[acc_addr];
    end
  end

  assign rdata_oe = q_valid && !oe_n && !snooze;
  assign rdata    = rdata_oe ? q : '0;
endmodule

// File: rtl/sram_burst_ctrl_chk.sv
module sram_burst_ctrl_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep,
  input logic             en_n,
  input logic             en_aux,
  input logic             en_aux_n,
  input logic             start_proc_n,
  input logic             start_ctrl_n,
  input logic             rdata_oe,
  input logic             snooze,
  input logic             sel,
  input logic             acc_valid,
  input logic             acc_we,
  input logic [LANES-1:0] acc_be,
  input logic             q_valid
);
  assert_proc_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !start_proc_n && !en_n && en_aux && !en_aux_n) |=> (acc_valid && !acc_we));

  assert_lane_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_we) |-> (acc_be != '0));

  assert_read_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_we) |=> q_valid);

  assert_desel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !start_ctrl_n && en_n) |=> (!acc_valid ##1 !rdata_oe));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !sel && start_proc_n && start_ctrl_n) |=> !acc_valid);

  assert_sleep_hiz_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !rdata_oe);
endmodule

bind sram_burst_ctrl sram_burst_ctrl_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .en_n(en_n), .en_aux(en_aux),
  .en_aux_n(en_aux_n), .start_proc_n(start_proc_n), .start_ctrl_n(start_ctrl_n),
  .rdata_oe(rdata_oe), .snooze(snooze), .sel(sel), .acc_valid(acc_valid),
  .acc_we(acc_we), .acc_be(acc_be), .q_valid(q_valid)
);

// File: tb/sram_burst_ctrl_tb.sv
`timescale 1ns/1ps
module sram_burst_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep, en_n, en_aux, en_aux_n, start_proc_n, start_ctrl_n, adv_n;
  logic gwr_n, bwr_n, burst_ilv, oe_n;
  logic [3:0] lane_wr_n;
  logic [7:0] addr;
  logic [35:0] wdata, rdata;
  logic rdata_oe;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sram_burst_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .en_n(en_n), .en_aux(en_aux),
    .en_aux_n(en_aux_n), .start_proc_n(start_proc_n), .start_ctrl_n(start_ctrl_n),
    .adv_n(adv_n), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  typedef struct packed {
    logic sl, sp, sc, adv, en, ea, ean, gw, bw;
    logic [3:0] lw;
    logic oe, ilv;
    logic [7:0] ad;
    logic [35:0] wd;
    logic eoe;
    logic [35:0] eq;
    logic [3:0] rq;
  } vec_t;

  localparam logic [35:0] D0  = {9'h101, 9'h102, 9'h103, 9'h104};
  localparam logic [35:0] D1  = {9'h011, 9'h012, 9'h013, 9'h014};
  localparam logic [35:0] D2  = {9'h1a1, 9'h0a2, 9'h1a3, 9'h0a4};
  localparam logic [35:0] D3  = {9'h0f1, 9'h1f2, 9'h0f3, 9'h1f4};
  localparam logic [35:0] WM  = {9'h055, 9'h066, 9'h077, 9'h088};
  localparam logic [35:0] M12 = {9'h1a1, 9'h066, 9'h1a3, 9'h088};
  localparam logic [35:0] W20 = {9'h0c1, 9'h1c2, 9'h0c3, 9'h1c4};
  localparam logic [35:0] JK  = {9'h1ee, 9'h0dd, 9'h1cc, 9'h0bb};
  localparam logic [35:0] Z   = 36'h0;

  // fields: sl sp sc adv en ea ean gw bw lw oe ilv ad wd eoe eq rq
  localparam vec_t VEC [28] = '{
    '{0,1,0,1,0,1,0,0,1,4'hF,0,0,8'h10,D0, 0,Z,  4'd1},  // R1 controller start write 0x10
    '{0,1,1,0,0,1,0,0,1,4'hF,0,0,8'h00,D1, 0,Z,  4'd1},  // R1 continue write 0x11
    '{0,1,1,0,0,1,0,0,1,4'hF,0,0,8'h00,D2, 0,Z,  4'd5},  // 0x12
    '{0,1,1,0,0,1,0,0,1,4'hF,0,0,8'h00,D3, 0,Z,  4'd5},  // 0x13
    '{0,0,1,1,0,1,0,0,1,4'hF,0,0,8'h12,JK, 0,Z,  4'd2},  // R2 processor start reads despite write request
    '{0,1,1,0,0,1,0,1,1,4'hF,0,0,8'h00,Z,  0,Z,  4'd5},  // linear -> 0x13
    '{0,1,1,0,0,1,0,1,1,4'hF,0,0,8'h00,Z,  1,D2, 4'd6},  // R6 linear wrap -> 0x10
    '{0,1,1,0,0,1,0,1,1,4'hF,0,0,8'h00,Z,  1,D3, 4'd5},  // R5 -> 0x11
    '{0,1,0,1,0,1,0,1,1,4'hF,0,1,8'h11,Z,  1,D0, 4'd5},  // R5 interleaved read from 0x11
    '{0,1,1,0,0,1,0,1,1,4'hF,0,1,8'h00,Z,  1,D1, 4'd5},  // 1^1 -> 0x10
    '{0,1,1,1,0,1,0,1,1,4'hF,0,1,8'h00,Z,  1,D1, 4'd5},  // suspend stays 0x10
    '{0,1,1,0,0,1,0,1,1,4'hF,0,1,8'h00,Z,  1,D0, 4'd5},  // 1^2 -> 0x13
    '{0,1,0,1,0,1,0,1,0,4'b1010,0,0,8'h12,WM,1,D0, 4'd4}, // R4 lanes 0 and 2 written
    '{0,1,0,1,0,1,0,1,1,4'hF,0,0,8'h12,Z,  1,D3, 4'd6},  // R6 read right after write
    '{0,0,1,1,1,1,0,1,1,4'hF,0,0,8'h13,Z,  0,Z,  4'd2},  // R2 masked processor start: suspend
    '{0,1,0,1,1,1,0,1,1,4'hF,0,0,8'h00,Z,  1,M12,4'd6},  // R7 controller start with en_n high
    '{0,1,1,0,0,1,0,0,1,4'hF,0,0,8'h00,JK, 1,M12,4'd7},  // R8 continue write while deselected
    '{0,1,0,1,0,0,0,0,1,4'hF,0,0,8'h13,JK, 0,Z,  4'd7},  // R7 en_aux low deselects
    '{0,0,1,1,0,1,1,1,1,4'hF,0,0,8'h13,Z,  0,Z,  4'd8},  // R7 en_aux_n high deselects
    '{0,0,1,1,0,1,0,1,1,4'hF,0,0,8'h13,Z,  0,Z,  4'd7},  // processor read 0x13
    '{0,1,1,1,0,1,0,0,1,4'hF,0,0,8'h00,W20,0,Z,  4'd3},  // R3 write after processor start, adv high
    '{0,0,1,1,0,1,0,1,1,4'hF,0,0,8'h12,Z,  1,D3, 4'd7},  // processor read 0x12
    '{0,1,1,0,0,1,0,0,1,4'hF,0,0,8'h00,JK, 0,Z,  4'd3},  // R3 write with adv low discarded
    '{0,1,0,1,0,1,0,1,1,4'hF,0,0,8'h13,Z,  1,M12,4'd8},  // read 0x13
    '{0,1,1,1,0,1,0,1,1,4'hF,0,0,8'h00,Z,  0,Z,  4'd3},  // no data from discarded write
    '{0,1,1,1,0,1,0,1,1,4'hF,0,0,8'h00,Z,  1,W20,4'd3},  // R3 0x13 holds accepted write only
    '{0,1,0,1,1,1,0,1,1,4'hF,0,0,8'h00,Z,  1,W20,4'd5},  // suspend repeat
    '{0,1,0,1,1,1,0,1,1,4'hF,1,0,8'h00,Z,  0,Z,  4'd9}   // R9 oe_n high hides data
  };

  task automatic check(input logic [3:0] rq, input logic oe_a, input logic [35:0] d_a,
                       input logic oe_e, input logic [35:0] d_e);
    checks++;
    if (oe_a !== oe_e || d_a !== d_e) begin
      errors++;
      $display("FAIL R%0d: oe=%b data=%h expected oe=%b data=%h", rq, oe_a, d_a, oe_e, d_e);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    sleep = v.sl; start_proc_n = v.sp; start_ctrl_n = v.sc; adv_n = v.adv;
    en_n = v.en; en_aux = v.ea; en_aux_n = v.ean; gwr_n = v.gw; bwr_n = v.bw;
    lane_wr_n = v.lw; oe_n = v.oe; burst_ilv = v.ilv; addr = v.ad; wdata = v.wd;
    #1;
    check(v.rq, rdata_oe, rdata, v.eoe, v.eq);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sleep = 0; en_n = 1; en_aux = 1; en_aux_n = 0; start_proc_n = 1; start_ctrl_n = 1;
    adv_n = 1; gwr_n = 1; bwr_n = 1; lane_wr_n = 4'hF; burst_ilv = 0; oe_n = 0;
    addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 check(4'd11, rdata_oe, rdata, 1'b0, Z);  // R11 during reset
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 28; i++) apply(VEC[i]);
    // R10 snooze sequence
    apply('{0,1,0,1,0,1,0,1,1,4'hF,0,0,8'h10,Z, 0,Z, 4'd10});
    apply('{1,1,1,1,0,1,0,1,1,4'hF,0,0,8'h00,Z, 0,Z, 4'd10});
    apply('{1,1,0,1,0,1,0,0,1,4'hF,0,0,8'h10,JK,0,Z, 4'd10});
    apply('{0,1,0,1,0,1,0,0,1,4'hF,0,0,8'h10,JK,0,Z, 4'd10});
    apply('{0,1,0,1,0,1,0,0,1,4'hF,0,0,8'h10,JK,0,Z, 4'd10});
    apply('{0,1,0,1,0,1,0,1,1,4'hF,0,0,8'h10,Z, 0,Z, 4'd10});
    apply('{0,1,0,1,1,1,0,1,1,4'hF,0,0,8'h00,Z, 0,Z, 4'd10});
    apply('{0,1,0,1,1,1,0,1,1,4'hF,0,0,8'h00,Z, 1,D0,4'd10});  // R10 writes during snooze ignored
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule